// File: doc/BRIEF.md
# Micro-op dispatch slot allocator

This block sits between decode and an out-of-order back end. Each clock cycle it decides which of up to `LANES` decoded instructions, presented in program order, are dispatched. Every cycle offers a fixed number of micro-op slots. An accepted instruction spends as many slots as it has micro-ops, capped at the width. Group flags can open or close a cycle. An instruction larger than the width takes a whole empty cycle, and its leftover micro-ops drain through the slots of the cycles that follow.

Dispatch is decided in the same cycle the instruction is presented, and nothing is buffered. An instruction is taken only when it has enough slots, enough free reorder-buffer entries for all of its micro-ops, a free physical register in each register file it writes, and a ready next stage. The lanes before it must also have been taken. The only state is the count of micro-ops still to drain. For the lane that blocks, separate flags report whether the reorder buffer or the register files caused the stall.

Top module: `uop_dispatch_alloc`

## Requirements
- R1: A synchronous active-high `rst` clears pending leftover micro-ops, so the first cycle after reset offers all W slots. W is `DISPATCH_W`, or `ISSUE_W` when `DISPATCH_W` is 0.
- R2: A lane is refused when no slots remain, or when min(uops, W) exceeds the slots left after the earlier lanes of the same cycle.
- R3: A lane with its begin-group bit set is accepted only if all W slots of the cycle are still unused, counting slots taken by draining leftovers.
- R4: Once a lane with its end-group bit set is accepted, every later lane in that cycle is refused.
- R5: A lane with uops > W is accepted only into a cycle with all W slots free. It uses every slot and leaves uops − W micro-ops pending.
- R6: With P micro-ops pending at the start of a cycle, that cycle offers W − min(P, W) slots to new lanes, and P drops by min(P, W).
- R7: While P > W at the start of a cycle, no lane is accepted in that cycle.
- R8: A lane needs the running sum of uops over lanes 0..k to be at most `robFree`. When this check alone blocks a lane whose slot checks pass, `stallRob` is 1.
- R9: For each register file f, the number of lanes 0..k whose write bit `instRfWrite[k*NUM_RF+f]` is set must be at most `rfFree[f*RF_W +: RF_W]`. When this blocks a lane whose slot checks pass, `stallRf` is 1.
- R10: With `nextReady` low, no lane is accepted.
- R11: `uopsDispatched` equals min(P, W) plus the sum of min(uops, W) over the lanes accepted in the cycle.
- R12: When `DISPATCH_W` is 0, the width used everywhere is `ISSUE_W`.
- R13: Lanes are taken in order. Lane k is accepted only if it is valid and every lane below it was accepted, so an invalid lane stops the lanes after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | LANES | Lane holds an instruction |
| instUops | input | LANES*UOP_W | Micro-op count per lane, lane 0 in the low bits |
| instBegin | input | LANES | Begin-group flag per lane |
| instEnd | input | LANES | End-group flag per lane |
| instRfWrite | input | LANES*NUM_RF | Bit k*NUM_RF+f: lane k writes register file f |
| robFree | input | ROB_W | Free reorder-buffer entries |
| rfFree | input | NUM_RF*RF_W | Free physical registers per file |
| nextReady | input | 1 | Next stage accepts this cycle |
| instReady | output | LANES | Lane dispatched this cycle |
| uopsDispatched | output | CNT_W | Micro-ops dispatched this cycle |
| stallRob | output | 1 | Blocking lane lacks reorder-buffer entries |
| stallRf | output | 1 | Blocking lane lacks a physical register |

## Verification
The main instance uses four lanes, W = 4 and 4-bit micro-op counts. With those values a single instruction can leave up to 11 micro-ops pending, which is enough for several fully blocked cycles followed by a partial drain. It also allows in-cycle slot exhaustion across lanes, and both group flags with earlier lanes present. A second, two-lane instance sets `DISPATCH_W` to 0 and `ISSUE_W` to 3. This exercises the fallback width and an odd width, where the spill and drain arithmetic no longer lines up with a power of two.

// File: rtl/uda_pkg.sv
package uda_pkg;
  localparam int SLOT_W = 8;

  // control -> lanes
  typedef struct packed {
    logic [SLOT_W-1:0] slotsOpen;
    logic              carryHold;
  } cycleStrobe_t;

  // lanes -> control
  typedef struct packed {
    logic              spillValid;
    logic [SLOT_W-1:0] spillUops;
    logic [SLOT_W-1:0] laneUops;
  } laneStrobe_t;
endpackage

// File: rtl/uda_ctrl.sv
module uda_ctrl
  import uda_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  laneStrobe_t       laneS,
  output cycleStrobe_t      cycS,
  output logic [SLOT_W-1:0] totalUops
);
  localparam logic [SLOT_W-1:0] W_S = SLOT_W'(W);

  logic [SLOT_W-1:0] carry;
  logic [SLOT_W-1:0] drain;

  always_comb begin
    drain          = (carry > W_S) ? W_S : carry;
    cycS.slotsOpen = W_S - drain;
    cycS.carryHold = carry > W_S;
    totalUops      = drain + laneS.laneUops;
  end

  always_ff @(posedge clk) begin
    if (rst) carry <= '0;
    else     carry <= (carry - drain) + (laneS.spillValid ? laneS.spillUops : '0);
  end
endmodule

// File: rtl/uda_lanes.sv
module uda_lanes
  import uda_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int W      = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6,
  parameter int NUM_RF = 2,
  parameter int RF_W   = 3
) (
  input  cycleStrobe_t            cycS,
  input  logic [LANES-1:0]        instValid,
  input  logic [LANES*UOP_W-1:0]  instUops,
  input  logic [LANES-1:0]        instBegin,
  input  logic [LANES-1:0]        instEnd,
  input  logic [LANES*NUM_RF-1:0] instRfWrite,
  input  logic [ROB_W-1:0]        robFree,
  input  logic [NUM_RF*RF_W-1:0]  rfFree,
  input  logic                    nextReady,
  output logic [LANES-1:0]        laneAccept,
  output laneStrobe_t             laneS,
  output logic                    stallRob,
  output logic                    stallRf
);
  localparam logic [SLOT_W-1:0] W_S = SLOT_W'(W);
  localparam int SUM_W = UOP_W + $clog2(LANES + 1);
  localparam int RC_W  = (SUM_W > ROB_W) ? SUM_W : ROB_W;
  localparam int CNT_L = $clog2(LANES + 1);
  localparam int FC_W  = ((CNT_L > RF_W) ? CNT_L : RF_W) + 1;

  logic [SLOT_W-1:0] laneU   [LANES];
  logic [SLOT_W-1:0] laneReq [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneU[k]   = SLOT_W'(instUops[k*UOP_W +: UOP_W]);
    assign laneReq[k] = (laneU[k] > W_S) ? W_S : laneU[k];
  end

  logic [SLOT_W-1:0] avail;
  logic              alive;
  logic [RC_W-1:0]   cumU;
  logic [FC_W-1:0]   rfCnt [NUM_RF];
  logic              robOk, rfOk, slotOk;

  always_comb begin
    avail      = cycS.slotsOpen;
    alive      = !cycS.carryHold;
    cumU       = '0;
    laneAccept = '0;
    laneS      = '0;
    stallRob   = 1'b0;
    stallRf    = 1'b0;
    robOk      = 1'b0;
    rfOk       = 1'b0;
    slotOk     = 1'b0;
    for (int f = 0; f < NUM_RF; f++) rfCnt[f] = '0;
    for (int k = 0; k < LANES; k++) begin
      cumU  = cumU + RC_W'(laneU[k]);
      robOk = cumU <= RC_W'(robFree);
      rfOk  = 1'b1;
      for (int f = 0; f < NUM_RF; f++) begin
        rfCnt[f] = rfCnt[f] + FC_W'(instRfWrite[k*NUM_RF+f]);
        if (rfCnt[f] > FC_W'(rfFree[f*RF_W +: RF_W])) rfOk = 1'b0;
      end
      slotOk = (avail != '0) && (laneReq[k] <= avail) &&
               !(instBegin[k] && (avail != W_S));
      if (alive && instValid[k]) begin
        if (slotOk && robOk && rfOk && nextReady) begin
          laneAccept[k]  = 1'b1;
          laneS.laneUops = laneS.laneUops + laneReq[k];
          if (laneU[k] > W_S) begin
            laneS.spillValid = 1'b1;
            laneS.spillUops  = laneU[k] - W_S;
            avail            = '0;
          end else begin
            avail = avail - laneU[k];
          end
          if (instEnd[k]) avail = '0;
        end else begin
          alive = 1'b0;
          if (slotOk) begin
            stallRob = !robOk;
            stallRf  = !rfOk;
          end
        end
      end else begin
        alive = 1'b0;
      end
    end
  end
endmodule

// File: rtl/uop_dispatch_alloc.sv
module uop_dispatch_alloc
  import uda_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int DISPATCH_W = 4,
  parameter int ISSUE_W    = 6,
  parameter int UOP_W      = 4,
  parameter int ROB_W      = 6,
  parameter int NUM_RF     = 2,
  parameter int RF_W       = 3,
  localparam int W_EFF     = (DISPATCH_W == 0) ? ISSUE_W : DISPATCH_W,
  localparam int CNT_W     = $clog2(W_EFF + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        instValid,
  input  logic [LANES*UOP_W-1:0]  instUops,
  input  logic [LANES-1:0]        instBegin,
  input  logic [LANES-1:0]        instEnd,
  input  logic [LANES*NUM_RF-1:0] instRfWrite,
  input  logic [ROB_W-1:0]        robFree,
  input  logic [NUM_RF*RF_W-1:0]  rfFree,
  input  logic                    nextReady,
  output logic [LANES-1:0]        instReady,
  output logic [CNT_W-1:0]        uopsDispatched,
  output logic                    stallRob,
  output logic                    stallRf
);
  cycleStrobe_t      cycS;
  laneStrobe_t       laneS;
  logic [SLOT_W-1:0] totalUops;

  uda_ctrl #(.W(W_EFF)) ctrl_i (
    .clk(clk), .rst(rst), .laneS(laneS), .cycS(cycS), .totalUops(totalUops)
  );

  uda_lanes #(
    .LANES(LANES), .W(W_EFF), .UOP_W(UOP_W), .ROB_W(ROB_W),
    .NUM_RF(NUM_RF), .RF_W(RF_W)
  ) lanes_i (
    .cycS(cycS), .instValid(instValid), .instUops(instUops),
    .instBegin(instBegin), .instEnd(instEnd), .instRfWrite(instRfWrite),
    .robFree(robFree), .rfFree(rfFree), .nextReady(nextReady),
    .laneAccept(instReady), .laneS(laneS),
    .stallRob(stallRob), .stallRf(stallRf)
  );

  assign uopsDispatched = CNT_W'(totalUops);
endmodule

// File: rtl/uda_checker.sv
module uda_checker #(
  parameter int LANES = 4,
  parameter int W     = 4,
  parameter int UOP_W = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] instValid,
  input logic [UOP_W-1:0] leadUops,
  input logic             nextReady,
  input logic [LANES-1:0] instReady,
  input logic [CNT_W-1:0] uopsDispatched,
  input logic             stallRob,
  input logic             stallRf
);
  a_r13_prefix: assert property (@(posedge clk) disable iff (rst)
    (instReady & (instReady + LANES'(1))) == '0);

  a_r13_valid_only: assert property (@(posedge clk) disable iff (rst)
    (instReady & ~instValid) == '0);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !nextReady |-> instReady == '0);

  a_r11_bound: assert property (@(posedge clk) disable iff (rst)
    int'(uopsDispatched) <= W);

  a_r7_deep_spill: assert property (@(posedge clk) disable iff (rst)
    (instReady[0] && int'(leadUops) >= 2 * W) |=>
      (instReady == '0 && int'(uopsDispatched) == W));

  a_r9_stall_cause: assert property (@(posedge clk) disable iff (rst)
    (stallRob || stallRf) |-> (instValid & ~instReady) != '0);
endmodule

bind uop_dispatch_alloc uda_checker #(
  .LANES(LANES), .W(W_EFF), .UOP_W(UOP_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .instValid(instValid), .leadUops(instUops[UOP_W-1:0]),
  .nextReady(nextReady), .instReady(instReady), .uopsDispatched(uopsDispatched),
  .stallRob(stallRob), .stallRf(stallRf)
);

// File: tb/uop_dispatch_alloc_tb_top.sv
module uop_dispatch_alloc_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // main instance: 4 lanes, W = 4
  logic        rst;
  logic [3:0]  vld, beg, endg, rdy;
  logic [15:0] uops;
  logic [7:0]  rfw;
  logic [5:0]  rob, rff;
  logic        nr, sr, sf;
  logic [2:0]  cnt;

  uop_dispatch_alloc #(.LANES(4), .DISPATCH_W(4), .ISSUE_W(6), .UOP_W(4),
                       .ROB_W(6), .NUM_RF(2), .RF_W(3)) dut_i (
    .clk(clk), .rst(rst), .instValid(vld), .instUops(uops), .instBegin(beg),
    .instEnd(endg), .instRfWrite(rfw), .robFree(rob), .rfFree(rff),
    .nextReady(nr), .instReady(rdy), .uopsDispatched(cnt),
    .stallRob(sr), .stallRf(sf));

  // second instance: width falls back to ISSUE_W = 3
  logic [1:0] vld0, rdy0;
  logic [7:0] uops0;
  logic [1:0] cnt0;
  logic       sr0, sf0;

  uop_dispatch_alloc #(.LANES(2), .DISPATCH_W(0), .ISSUE_W(3), .UOP_W(4),
                       .ROB_W(6), .NUM_RF(2), .RF_W(3)) dut0_i (
    .clk(clk), .rst(rst), .instValid(vld0), .instUops(uops0), .instBegin(2'b00),
    .instEnd(2'b00), .instRfWrite(4'h0), .robFree(6'd63), .rfFree(6'o77),
    .nextReady(1'b1), .instReady(rdy0), .uopsDispatched(cnt0),
    .stallRob(sr0), .stallRf(sf0));

  typedef struct packed {
    logic [3:0]  vld;
    logic [15:0] uops;
    logic [3:0]  beg;
    logic [3:0]  endg;
    logic [7:0]  rfw;
    logic [5:0]  rob;
    logic [5:0]  rff;
    logic        nr;
    logic [3:0]  expRdy;
    logic [2:0]  expCnt;
    logic        expSr;
    logic        expSf;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'hF,16'h1111,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'hF,3'd4,1'b0,1'b0,8'd11}, // R11 four single-uop lanes
    '{4'h7,16'h0122,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h3,3'd4,1'b0,1'b0,8'd2},  // R2 slots run out
    '{4'h3,16'h0023,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd3,1'b0,1'b0,8'd2},  // R2 need 2, have 1
    '{4'h3,16'h0011,4'h2,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd1,1'b0,1'b0,8'd3},  // R3 begin on lane 1 refused
    '{4'h3,16'h0022,4'h1,4'h0,8'h00,6'd63,6'o77,1'b1,4'h3,3'd4,1'b0,1'b0,8'd3},  // R3 begin on lane 0 taken
    '{4'h3,16'h0011,4'h0,4'h1,8'h00,6'd63,6'o77,1'b1,4'h1,3'd1,1'b0,1'b0,8'd4},  // R4 end closes cycle
    '{4'h3,16'h0063,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd3,1'b0,1'b0,8'd5},  // R5 wide lane needs empty cycle
    '{4'h3,16'h0016,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd4,1'b0,1'b0,8'd5},  // R5 6 uops, 2 pending
    '{4'h3,16'h0012,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd4,1'b0,1'b0,8'd6},  // R6 drain 2, 2 slots left
    '{4'h3,16'h001D,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd4,1'b0,1'b0,8'd5},  // R5 13 uops, 9 pending
    '{4'h1,16'h0001,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h0,3'd4,1'b0,1'b0,8'd7},  // R7 9 pending, blocked
    '{4'h1,16'h0001,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h0,3'd4,1'b0,1'b0,8'd7},  // R7 5 pending, blocked
    '{4'h1,16'h0003,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd4,1'b0,1'b0,8'd6},  // R6 1 pending, 3 slots
    '{4'h3,16'h0021,4'h0,4'h0,8'h00,6'd2, 6'o77,1'b1,4'h1,3'd1,1'b1,1'b0,8'd8},  // R8 reorder buffer short
    '{4'h3,16'h0011,4'h0,4'h0,8'h05,6'd63,6'o71,1'b1,4'h1,3'd1,1'b0,1'b1,8'd9},  // R9 file 0 has one reg
    '{4'h1,16'h0001,4'h0,4'h0,8'h02,6'd63,6'o07,1'b1,4'h0,3'd0,1'b0,1'b1,8'd9},  // R9 file 1 empty
    '{4'h3,16'h0011,4'h0,4'h0,8'h00,6'd63,6'o77,1'b0,4'h0,3'd0,1'b0,1'b0,8'd10}, // R10 next stage busy
    '{4'h2,16'h0011,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h0,3'd0,1'b0,1'b0,8'd13}, // R13 lane 0 invalid
    '{4'h5,16'h0101,4'h0,4'h0,8'h00,6'd63,6'o77,1'b1,4'h1,3'd1,1'b0,1'b0,8'd13}, // R13 gap stops lane 2
    '{4'h1,16'h0001,4'h0,4'h0,8'h01,6'd0, 6'o70,1'b1,4'h0,3'd0,1'b1,1'b1,8'd8}   // R8 R9 both short
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic [15:0] u, input logic [3:0] b,
                       input logic [3:0] e, input logic [7:0] w, input logic [5:0] r,
                       input logic [5:0] f, input logic n);
    @(negedge clk);
    vld = v; uops = u; beg = b; endg = e; rfw = w; rob = r; rff = f; nr = n;
    #1;
  endtask

  task automatic drive0(input logic [1:0] v, input logic [7:0] u);
    @(negedge clk);
    vld0 = v; uops0 = u;
    #1;
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; vld = '0; uops = '0; beg = '0; endg = '0; rfw = '0;
    rob = 6'd63; rff = 6'o77; nr = 1'b1; vld0 = '0; uops0 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    // R1 reset state: nothing offered, nothing dispatched
    chk("R1 reset ready", int'(rdy), 0);
    chk("R1 reset count", int'(cnt), 0);
    drive(4'h1, 16'h0004, 4'h0, 4'h0, 8'h00, 6'd63, 6'o77, 1'b1);
    chk("R1 full width after reset", int'(rdy), 1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].vld, VEC[i].uops, VEC[i].beg, VEC[i].endg, VEC[i].rfw,
            VEC[i].rob, VEC[i].rff, VEC[i].nr);
      chk($sformatf("R%0d vec %0d ready", VEC[i].req, i), int'(rdy), int'(VEC[i].expRdy));
      chk($sformatf("R%0d vec %0d count", VEC[i].req, i), int'(cnt), int'(VEC[i].expCnt));
      chk($sformatf("R%0d vec %0d stallRob", VEC[i].req, i), int'(sr), int'(VEC[i].expSr));
      chk($sformatf("R%0d vec %0d stallRf", VEC[i].req, i), int'(sf), int'(VEC[i].expSf));
    end

    // R1: reset clears pending micro-ops
    drive(4'h1, 16'h000D, 4'h0, 4'h0, 8'h00, 6'd63, 6'o77, 1'b1);
    chk("R1 wide lane taken", int'(rdy), 1);
    @(negedge clk); rst = 1'b1; vld = '0;
    @(negedge clk); rst = 1'b0;
    drive(4'h1, 16'h0004, 4'h0, 4'h0, 8'h00, 6'd63, 6'o77, 1'b1);
    chk("R1 carry cleared ready", int'(rdy), 1);
    chk("R1 carry cleared count", int'(cnt), 4);

    // R3: begin-group refused while leftovers use a slot
    drive(4'h1, 16'h0005, 4'h0, 4'h0, 8'h00, 6'd63, 6'o77, 1'b1);
    chk("R5 five uops taken", int'(rdy), 1);
    drive(4'h1, 16'h0001, 4'h1, 4'h0, 8'h00, 6'd63, 6'o77, 1'b1);
    chk("R3 begin during drain ready", int'(rdy), 0);
    chk("R6 drain count", int'(cnt), 1);
    drive(4'h1, 16'h0001, 4'h1, 4'h0, 8'h00, 6'd63, 6'o77, 1'b1);
    chk("R3 begin in clean cycle", int'(rdy), 1);
    vld = '0;

    // R12: fallback width of 3
    drive0(2'b11, 8'h13);
    chk("R12 width3 ready", int'(rdy0), 1);
    chk("R12 width3 count", int'(cnt0), 3);
    drive0(2'b01, 8'h05);
    chk("R12 spill ready", int'(rdy0), 1);
    chk("R12 spill count", int'(cnt0), 3);
    drive0(2'b01, 8'h01);
    chk("R12 drain then lane ready", int'(rdy0), 1);
    chk("R12 drain then lane count", int'(cnt0), 3);
    vld0 = '0;

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule